// File: doc/BRIEF.md
# JTAG Flash Word-Programming Sequencer

This block is the host side of a flash programmer. It drives a 4-wire JTAG port (TCK, TMS, TDI; TDO is not used) so that the target's own flash controller writes a stream of 16-bit words into on-chip flash. Before it starts, the target CPU is assumed to be halted and its TAP controller to sit in Run-Test/Idle. While the TAP rests in Run-Test/Idle, the TDI line carries the target's test clock. The sequencer moves that level high and low to advance the target, and it shifts instruction and data registers in between.

After a `start` pulse, the sequencer drives the test clock low. It then writes the three flash-controller registers that unlock writing and select the clock, and raises `in_ready` for the first address/data pair. Each word is written at its own address, so any order of addresses works. After each word the sequencer switches the target to read mode and issues a counted burst of test-clock cycles, which covers the programming time. When the word flagged `in_last` has finished its burst, the sequencer disables write access, sets the lock bit, leaves the test clock high and pulses `done`.

Each TCK half period lasts `half_div`+1 system clocks. This lets the host set the test clock rate that the flash timing needs.

Top module: `flash_prog_seq`

## Requirements
- R1: During and after reset with no start: tck=0, tms=0, tdi=1 (test clock parked high), busy=0, done=0, in_ready=0.
- R2: On start, busy is 1 from the next cycle, and the first action on the port is the test clock driven low (tdi falling while the TAP is in Run-Test/Idle).
- R3: A register write is, in order: IR shift of OPC_SIG, DR shift of 0x2408, IR shift of OPC_ADDR, DR shift of the address, IR shift of OPC_WDATA, DR shift of the data, then test clock high, then test clock low. Three such writes come first: 0xA540 to 0x0128, 0xA540 to 0x012A, 0xA500 to 0x012C.
- R4: Each accepted word produces one write of the R3 form with the word's own address and data, and arbitrary non-consecutive addresses are honoured.
- R5: After each word write, an IR shift of OPC_SIG and a DR shift of 0x2409 follow, then BURST_CYCLES (35) full test-clock cycles, each high then low.
- R6: in_ready is 1 only while waiting for a word. Word k (counting from 0) is accepted only after exactly 7 + 72·k test-clock level changes since start.
- R7: After the burst of the word marked in_last, 0xA500 is written to 0x0128 and 0xA510 to 0x012C. The last write ends after its test-clock-high step, which leaves tdi=1.
- R8: busy stays 1 from start until the closing write completes. done is a one-cycle pulse during which busy is 0.
- R9: IR shifts are 8 bits and DR shifts are 16 bits, LSB first. Each shift walks Select, Capture, Shift, Exit1 and Update and returns the TAP to Run-Test/Idle, where tdi holds only the test-clock level.
- R10: TCK is high for exactly half_div+1 system clocks per bit. Each test-clock level is held for at least 2·(half_div+1) system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_div | input | DIV_W | System clocks per TCK half period, minus one |
| start | input | 1 | Begin a programming sequence (sampled when idle) |
| in_valid | input | 1 | Address/data pair is present |
| in_ready | output | 1 | Sequencer takes the pair this cycle if in_valid |
| in_addr | input | DR_W | Flash word address |
| in_data | input | DR_W | Word to program |
| in_last | input | 1 | This pair is the final one |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at completion |
| tck | output | 1 | JTAG test clock |
| tms | output | 1 | JTAG mode select |
| tdi | output | 1 | JTAG data in; carries the target test clock in Run-Test/Idle |

## Verification
A wrong sub-step index or a register index that moves at the wrong time shows up as a wrong instruction or data value in the next decoded shift. That happens within one TAP walk, a few dozen TCK cycles. A burst counter that is off by one changes the number of test-clock edges before `in_ready` rises, so the check at acceptance catches it before the next word reaches the port. A driver step fault breaks the TAP walk or the bit count and corrupts the very shift it occurs in. A wrong end condition appears as a missing lock write or as tdi left low when `done` pulses.

// File: rtl/fps_pkg.sv
package fps_pkg;

    // operation handed from the sequencer to the port driver
    typedef enum logic [1:0] {
        OP_IR   = 2'd0,
        OP_DR   = 2'd1,
        OP_TSET = 2'd2,
        OP_TCLR = 2'd3
    } op_kind_t;

    // sequencer phases
    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_PREP   = 3'd1,
        S_CFG    = 3'd2,
        S_WAIT   = 3'd3,
        S_WORD   = 3'd4,
        S_RDMODE = 3'd5,
        S_BURST  = 3'd6,
        S_FIN    = 3'd7
    } seq_st_t;

endpackage

// File: rtl/fps_tick.sv
module fps_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (!en) begin
            cnt_d = '0;
        end else if (cnt_q == half_div) begin
            tick  = 1'b1;
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/fps_tap_drv.sv
module fps_tap_drv
    import fps_pkg::*;
#(
    parameter int IR_W  = 8,
    parameter int DR_W  = 16,
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] half_div,
    input  logic             req,
    input  op_kind_t         req_kind,
    input  logic [DR_W-1:0]  req_val,
    output logic             drv_busy,
    output logic             drv_done,
    output logic             tck,
    output logic             tms,
    output logic             tdi
);

    localparam int LONG_W    = (IR_W > DR_W) ? IR_W : DR_W;
    localparam int MAX_STEPS = 4 + LONG_W + 2;
    localparam int STEP_W    = $clog2(MAX_STEPS + 1);

    typedef struct packed {
        logic              active;
        logic              half;
        logic [STEP_W-1:0] step;
        op_kind_t          kind;
        logic [DR_W-1:0]   sreg;
        logic              lvl;
        logic              done;
    } drv_t;

    drv_t d, q;
    logic tick;
    logic is_shift, in_bits;
    logic [STEP_W-1:0] pre_n, bit_hi, last_step;

    fps_tick #(.DIV_W(DIV_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (q.active),
        .half_div (half_div),
        .tick     (tick)
    );

    always_comb begin
        is_shift  = (q.kind == OP_IR) || (q.kind == OP_DR);
        pre_n     = (q.kind == OP_IR) ? STEP_W'(4) : STEP_W'(3);
        bit_hi    = pre_n + ((q.kind == OP_IR) ? STEP_W'(IR_W) : STEP_W'(DR_W)) - STEP_W'(1);
        last_step = is_shift ? bit_hi + STEP_W'(2) : '0;
        in_bits   = is_shift && (q.step >= pre_n) && (q.step <= bit_hi);

        d      = q;
        d.done = 1'b0;
        if (!q.active) begin
            if (req) begin
                d.active = 1'b1;
                d.half   = 1'b0;
                d.step   = '0;
                d.kind   = req_kind;
                d.sreg   = req_val;
            end
        end else if (tick) begin
            if (!q.half) begin
                d.half = 1'b1;
            end else begin
                d.half = 1'b0;
                if (in_bits) d.sreg = q.sreg >> 1;
                if (q.step == last_step) begin
                    d.active = 1'b0;
                    d.done   = 1'b1;
                    if (q.kind == OP_TSET) d.lvl = 1'b1;
                    if (q.kind == OP_TCLR) d.lvl = 1'b0;
                end else begin
                    d.step = q.step + STEP_W'(1);
                end
            end
        end
    end

    // port levels
    always_comb begin
        tck = q.active && is_shift && q.half;
        tms = 1'b0;
        if (q.active && is_shift) begin
            if (q.step < pre_n)
                tms = (q.kind == OP_IR) ? (q.step < STEP_W'(2)) : (q.step == '0);
            else if (in_bits)
                tms = (q.step == bit_hi);
            else if (q.step == bit_hi + STEP_W'(1))
                tms = 1'b1;
        end
        if (q.active && in_bits)            tdi = q.sreg[0];
        else if (q.active && q.kind == OP_TSET) tdi = 1'b1;
        else if (q.active && q.kind == OP_TCLR) tdi = 1'b0;
        else                                tdi = q.lvl;
    end

    assign drv_busy = q.active;
    assign drv_done = q.done;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q        <= '0;
            q.kind   <= OP_TCLR;
            q.lvl    <= 1'b1;
        end else begin
            q <= d;
        end
    end

    AST_REQ_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> !q.active); // R9
    AST_LVL_HELD_IN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.active && is_shift) |=> $stable(q.lvl)); // R9
    AST_DONE_AFTER_WORK: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> $past(q.active)); // R9

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
    import fps_pkg::*;
#(
    parameter int              IR_W         = 8,
    parameter int              DR_W         = 16,
    parameter int              DIV_W        = 16,
    parameter int              BURST_CYCLES = 35,
    parameter logic [IR_W-1:0] OPC_SIG      = 8'h13,
    parameter logic [IR_W-1:0] OPC_ADDR     = 8'h83,
    parameter logic [IR_W-1:0] OPC_WDATA    = 8'h85,
    parameter logic [DR_W-1:0] REG_ACC_ADDR = 16'h0128,
    parameter logic [DR_W-1:0] REG_CLK_ADDR = 16'h012A,
    parameter logic [DR_W-1:0] REG_LCK_ADDR = 16'h012C,
    parameter logic [DR_W-1:0] VAL_UNLOCK   = 16'hA540,
    parameter logic [DR_W-1:0] VAL_CLKSEL   = 16'hA540,
    parameter logic [DR_W-1:0] VAL_CLEAR    = 16'hA500,
    parameter logic [DR_W-1:0] VAL_WRDIS    = 16'hA500,
    parameter logic [DR_W-1:0] VAL_LOCK     = 16'hA510,
    parameter logic [DR_W-1:0] SIG_WRITE    = 16'h2408,
    parameter logic [DR_W-1:0] SIG_READ     = 16'h2409
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] half_div,
    input  logic             start,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [DR_W-1:0]  in_addr,
    input  logic [DR_W-1:0]  in_data,
    input  logic             in_last,
    output logic             busy,
    output logic             done,
    output logic             tck,
    output logic             tms,
    output logic             tdi
);

    localparam int BURST_OPS = 2 * BURST_CYCLES;
    localparam int CNT_W     = $clog2(BURST_OPS + 1);

    typedef struct packed {
        seq_st_t          st;
        logic [2:0]       sub;
        logic [1:0]       idx;
        logic [CNT_W-1:0] cnt;
        logic             issued;
        logic [DR_W-1:0]  addr;
        logic [DR_W-1:0]  data;
        logic             last;
        logic             done;
    } seq_t;

    seq_t d, q;

    logic            op_req;
    op_kind_t        op_kind;
    logic [DR_W-1:0] op_val;
    logic            drv_busy, drv_done;
    logic [DR_W-1:0] tgt_addr, tgt_data;
    op_kind_t        wr_kind;
    logic [DR_W-1:0] wr_val;
    logic            final_write;

    fps_tap_drv #(.IR_W(IR_W), .DR_W(DR_W), .DIV_W(DIV_W)) u_drv (
        .clk      (clk),
        .rst_n    (rst_n),
        .half_div (half_div),
        .req      (op_req),
        .req_kind (op_kind),
        .req_val  (op_val),
        .drv_busy (drv_busy),
        .drv_done (drv_done),
        .tck      (tck),
        .tms      (tms),
        .tdi      (tdi)
    );

    // target of the register write in progress
    always_comb begin
        tgt_addr = q.addr;
        tgt_data = q.data;
        if (q.st == S_CFG) begin
            case (q.idx)
                2'd0:    begin tgt_addr = REG_ACC_ADDR; tgt_data = VAL_UNLOCK; end
                2'd1:    begin tgt_addr = REG_CLK_ADDR; tgt_data = VAL_CLKSEL; end
                default: begin tgt_addr = REG_LCK_ADDR; tgt_data = VAL_CLEAR;  end
            endcase
        end else if (q.st == S_FIN) begin
            if (q.idx == 2'd0) begin tgt_addr = REG_ACC_ADDR; tgt_data = VAL_WRDIS; end
            else               begin tgt_addr = REG_LCK_ADDR; tgt_data = VAL_LOCK;  end
        end
        case (q.sub)
            3'd0:    begin wr_kind = OP_IR;   wr_val = DR_W'(OPC_SIG);   end
            3'd1:    begin wr_kind = OP_DR;   wr_val = SIG_WRITE;        end
            3'd2:    begin wr_kind = OP_IR;   wr_val = DR_W'(OPC_ADDR);  end
            3'd3:    begin wr_kind = OP_DR;   wr_val = tgt_addr;         end
            3'd4:    begin wr_kind = OP_IR;   wr_val = DR_W'(OPC_WDATA); end
            3'd5:    begin wr_kind = OP_DR;   wr_val = tgt_data;         end
            3'd6:    begin wr_kind = OP_TSET; wr_val = '0;               end
            default: begin wr_kind = OP_TCLR; wr_val = '0;               end
        endcase
        final_write = (q.st == S_FIN) && (q.idx == 2'd1);
    end

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        op_req  = 1'b0;
        op_kind = wr_kind;
        op_val  = wr_val;

        if ((q.st != S_IDLE) && (q.st != S_WAIT) && !q.issued) begin
            op_req   = 1'b1;
            d.issued = 1'b1;
        end
        if (drv_done) d.issued = 1'b0;

        case (q.st)
            S_IDLE: begin
                op_req   = 1'b0;
                d.issued = 1'b0;
                if (start) d.st = S_PREP;
            end
            S_PREP: begin
                op_kind = OP_TCLR;
                if (drv_done) begin
                    d.st  = S_CFG;
                    d.sub = '0;
                    d.idx = '0;
                end
            end
            S_CFG, S_WORD, S_FIN: begin
                if (drv_done) begin
                    if (final_write && q.sub == 3'd6) begin
                        d.st   = S_IDLE;
                        d.done = 1'b1;
                    end else if (q.sub == 3'd7) begin
                        d.sub = '0;
                        if (q.st == S_CFG) begin
                            if (q.idx == 2'd2) d.st = S_WAIT;
                            else               d.idx = q.idx + 2'd1;
                        end else if (q.st == S_WORD) begin
                            d.st = S_RDMODE;
                        end else begin
                            d.idx = q.idx + 2'd1;
                        end
                    end else begin
                        d.sub = q.sub + 3'd1;
                    end
                end
            end
            S_WAIT: begin
                if (in_valid) begin
                    d.addr = in_addr;
                    d.data = in_data;
                    d.last = in_last;
                    d.sub  = '0;
                    d.st   = S_WORD;
                end
            end
            S_RDMODE: begin
                if (q.sub == 3'd0) begin op_kind = OP_IR; op_val = DR_W'(OPC_SIG); end
                else               begin op_kind = OP_DR; op_val = SIG_READ;       end
                if (drv_done) begin
                    if (q.sub == 3'd1) begin
                        d.st  = S_BURST;
                        d.cnt = '0;
                    end else begin
                        d.sub = q.sub + 3'd1;
                    end
                end
            end
            S_BURST: begin
                op_kind = q.cnt[0] ? OP_TCLR : OP_TSET;
                op_val  = '0;
                if (drv_done) begin
                    if (q.cnt == CNT_W'(BURST_OPS - 1)) begin
                        d.sub = '0;
                        d.idx = '0;
                        d.st  = q.last ? S_FIN : S_WAIT;
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    assign in_ready = (q.st == S_WAIT);
    assign busy     = (q.st != S_IDLE);
    assign done     = q.done;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done); // R8
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> !busy); // R8
    AST_READY_DRV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !drv_busy); // R6
    AST_END_CLOCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> tdi); // R7
    AST_BURST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_BURST) |-> (q.cnt < CNT_W'(BURST_OPS))); // R5

endmodule

// File: tb/flash_prog_seq_test.sv
module flash_prog_seq_test;

    localparam logic [7:0]  T_OPC_SIG  = 8'h13;
    localparam logic [7:0]  T_OPC_ADDR = 8'h83;
    localparam logic [7:0]  T_OPC_DATA = 8'h85;
    localparam int          T_BURST    = 35;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] half_div = 16'd1;
    logic        start = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_addr = '0;
    logic [15:0] in_data = '0;
    logic        in_last = 1'b0;
    logic        busy, done, tck, tms, tdi;

    always #5 clk = ~clk;

    flash_prog_seq #(
        .DIV_W(16), .BURST_CYCLES(T_BURST),
        .OPC_SIG(T_OPC_SIG), .OPC_ADDR(T_OPC_ADDR), .OPC_WDATA(T_OPC_DATA)
    ) uut (
        .clk(clk), .rst_n(rst_n), .half_div(half_div), .start(start),
        .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
        .in_data(in_data), .in_last(in_last), .busy(busy), .done(done),
        .tck(tck), .tms(tms), .tdi(tdi)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- port monitor with TAP model ----------------
    typedef enum int {T_RTI, T_SDR, T_CDR, T_SHDR, T_E1DR, T_PDR, T_E2DR, T_UDR,
                      T_SIR, T_CIR, T_SHIR, T_E1IR, T_PIR, T_E2IR, T_UIR, T_TLR} tap_t;

    function automatic tap_t tap_next(tap_t s, logic m);
        case (s)
            T_RTI:  return m ? T_SDR  : T_RTI;
            T_SDR:  return m ? T_SIR  : T_CDR;
            T_CDR:  return m ? T_E1DR : T_SHDR;
            T_SHDR: return m ? T_E1DR : T_SHDR;
            T_E1DR: return m ? T_UDR  : T_PDR;
            T_PDR:  return m ? T_E2DR : T_PDR;
            T_E2DR: return m ? T_UDR  : T_SHDR;
            T_UDR:  return m ? T_SDR  : T_RTI;
            T_SIR:  return m ? T_TLR  : T_CIR;
            T_CIR:  return m ? T_E1IR : T_SHIR;
            T_SHIR: return m ? T_E1IR : T_SHIR;
            T_E1IR: return m ? T_UIR  : T_PIR;
            T_PIR:  return m ? T_E2IR : T_PIR;
            T_E2IR: return m ? T_UIR  : T_SHIR;
            T_UIR:  return m ? T_SDR  : T_RTI;
            default: return m ? T_TLR : T_RTI;
        endcase
    endfunction

    logic [19:0] ev_obs [0:1023];
    logic [19:0] ev_exp [0:1023];
    string       ev_tag [0:1023];
    int n_obs = 0, n_exp = 0, n_tclk = 0;
    int gap_bad = 0, tck_bad = 0, busy_bad = 0, bad_len = 0;
    int cur_div = 1;
    int cyc = 0, rise_cyc = 0, last_tclk_cyc = 0;
    bit last_was_tclk = 0, running = 0, mon_clear = 0, tck_prev = 0;
    tap_t tap = T_RTI;
    logic lvl = 1'b1;
    logic [7:0]  ir_sh = '0;
    logic [15:0] dr_sh = '0;
    int ir_n = 0, dr_n = 0;

    function void rec(input logic [19:0] e);
        if (n_obs < 1024) ev_obs[n_obs] = e;
        n_obs++;
    endfunction

    always @(negedge clk) begin
        cyc++;
        if (mon_clear) begin
            n_obs = 0; n_tclk = 0; gap_bad = 0; tck_bad = 0; busy_bad = 0;
            bad_len = 0; last_was_tclk = 0;
        end else if (rst_n) begin
            if (tck && !tck_prev) begin
                rise_cyc = cyc;
                if (tap == T_SHIR) begin ir_sh = {tdi, ir_sh[7:1]}; ir_n++; end
                if (tap == T_SHDR) begin dr_sh = {tdi, dr_sh[15:1]}; dr_n++; end
                tap = tap_next(tap, tms);
                if (tap == T_CIR) ir_n = 0;
                if (tap == T_CDR) dr_n = 0;
                if (tap == T_UIR) begin
                    if (ir_n != 8) bad_len++;
                    rec({4'd1, 8'h00, ir_sh});
                end
                if (tap == T_UDR) begin
                    if (dr_n != 16) bad_len++;
                    rec({4'd2, dr_sh});
                end
                last_was_tclk = 0;
            end
            if (!tck && tck_prev && (cyc - rise_cyc != cur_div + 1)) tck_bad++;
            if (tap == T_RTI && tdi !== lvl) begin
                lvl = tdi;
                if (last_was_tclk && (cyc - last_tclk_cyc < 2 * (cur_div + 1))) gap_bad++;
                rec({4'd3, 15'd0, tdi});
                n_tclk++;
                last_tclk_cyc = cyc;
                last_was_tclk = 1;
            end
            if (running && !busy && !done) busy_bad++;
            tck_prev = tck;
        end
    end

    // ---------------- expected stream ----------------
    function void exp_push(input logic [19:0] e, input string tag);
        if (n_exp < 1024) begin ev_exp[n_exp] = e; ev_tag[n_exp] = tag; end
        n_exp++;
    endfunction

    function void exp_write(input logic [15:0] a, input logic [15:0] dt,
                            input bit is_final, input string tag);
        exp_push({4'd1, 8'h00, T_OPC_SIG}, tag);
        exp_push({4'd2, 16'h2408}, tag);
        exp_push({4'd1, 8'h00, T_OPC_ADDR}, tag);
        exp_push({4'd2, a}, tag);
        exp_push({4'd1, 8'h00, T_OPC_DATA}, tag);
        exp_push({4'd2, dt}, tag);
        exp_push({4'd3, 16'd1}, tag);
        if (!is_final) exp_push({4'd3, 16'd0}, tag);
    endfunction

    logic [15:0] w_addr [0:7];
    logic [15:0] w_data [0:7];

    task automatic run_prog(input int nw, input int div);
        int fails;
        cur_div  = div;
        half_div = 16'(div);
        @(posedge clk); mon_clear = 1;
        @(posedge clk); mon_clear = 0;
        n_exp = 0;
        exp_push({4'd3, 16'd0}, "R2");
        exp_write(16'h0128, 16'hA540, 0, "R3");
        exp_write(16'h012A, 16'hA540, 0, "R3");
        exp_write(16'h012C, 16'hA500, 0, "R3");
        for (int k = 0; k < nw; k++) begin
            exp_write(w_addr[k], w_data[k], 0, "R4");
            exp_push({4'd1, 8'h00, T_OPC_SIG}, "R5");
            exp_push({4'd2, 16'h2409}, "R5");
            for (int b = 0; b < T_BURST; b++) begin
                exp_push({4'd3, 16'd1}, "R5");
                exp_push({4'd3, 16'd0}, "R5");
            end
        end
        exp_write(16'h0128, 16'hA500, 0, "R7");
        exp_write(16'h012C, 16'hA510, 1, "R7");

        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(busy == 1'b1, "R2", "busy after start", 32'(busy), 32'd1);
        running = 1;
        for (int k = 0; k < nw; k++) begin
            repeat ($urandom % 12) @(negedge clk);
            in_valid = 1'b1; in_addr = w_addr[k]; in_data = w_data[k];
            in_last  = (k == nw - 1);
            while (!in_ready) @(negedge clk);
            check(n_tclk == 7 + 72 * k, "R6", "test clock edges before accept",
                  32'(n_tclk), 32'(7 + 72 * k));
            @(negedge clk);
            in_valid = 1'b0; in_addr = 16'($urandom); in_data = 16'($urandom);
            in_last = 1'($urandom);
        end
        while (!done) @(negedge clk);
        running = 0;
        check(busy == 1'b0, "R8", "busy at done", 32'(busy), 32'd0);
        check(tdi == 1'b1, "R7", "test clock high at end", 32'(tdi), 32'd1);
        @(negedge clk);
        check(done == 1'b0, "R8", "done width", 32'(done), 32'd0);
        check(busy_bad == 0, "R8", "busy gaps", 32'(busy_bad), 32'd0);
        check(n_obs == n_exp, "R9", "event count", 32'(n_obs), 32'(n_exp));
        check(bad_len == 0, "R9", "shift length errors", 32'(bad_len), 32'd0);
        check(tck_bad == 0, "R10", "tck high width errors", 32'(tck_bad), 32'd0);
        check(gap_bad == 0, "R10", "short test clock phases", 32'(gap_bad), 32'd0);
        fails = 0;
        for (int i = 0; i < n_exp && i < n_obs && i < 1024; i++) begin
            checks++;
            if (ev_obs[i] !== ev_exp[i]) begin
                errors++; fails++;
                $display("FAIL %s event %0d: actual %0h expected %0h",
                         ev_tag[i], i, ev_obs[i], ev_exp[i]);
                if (fails >= 5) break;
            end
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        int seed_val;
        seed_val = $urandom(32'h5eed);
        repeat (3) @(negedge clk);
        check(tck == 0 && tms == 0, "R1", "tck/tms in reset", {30'd0, tck, tms}, 32'd0);
        check(tdi == 1'b1, "R1", "tdi in reset", 32'(tdi), 32'd1);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(busy == 0 && done == 0 && in_ready == 0, "R1", "idle outputs",
              {29'd0, busy, done, in_ready}, 32'd0);
        check(tdi == 1'b1 && tck == 1'b0, "R1", "idle port", {30'd0, tdi, tck}, 32'd2);

        // directed: single word, half_div 1
        w_addr[0] = 16'hF000; w_data[0] = 16'h1234;
        run_prog(1, 1);

        // directed: non-consecutive addresses, extreme data, fastest divider
        w_addr[0] = 16'hFFFE; w_data[0] = 16'h0000;
        w_addr[1] = 16'hC000; w_data[1] = 16'hFFFF;
        w_addr[2] = 16'hE002; w_data[2] = 16'hA5A5;
        run_prog(3, 0);

        // random runs
        for (int r = 0; r < 3; r++) begin
            int nw;
            nw = 1 + int'($urandom % 4);
            for (int k = 0; k < nw; k++) begin
                w_addr[k] = 16'($urandom) & 16'hFFFE;
                w_data[k] = 16'($urandom);
            end
            run_prog(nw, int'($urandom % 3));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule